// File: doc/BRIEF.md
# Hashed Set-Associative Page Translator

This block turns a 64-bit virtual address into a physical frame number using an inverted tag memory with exactly one entry per physical frame. The 54-bit virtual page number is XOR-folded down to a 9-bit set index. All four ways of that set are compared against the full page number, and the position of the matching entry (set and way) is the frame number. The 10-bit page offset is carried through untouched. Because the table covers every frame, a miss is not followed by any walk. It is reported as a page fault, and a miss handler is expected to bring the page in from backing store.

The lookup is pipelined with a fixed latency, so it can overlap the data memory read that uses the same address. A maintenance port lets the miss handler install a page number into a chosen set and way, or drop an entry. On a miss, the response also suggests which way the handler should replace.

Top module: `hashed_page_xlat`

## Requirements
- R1: A request sampled with `req_valid` high produces exactly one response with `rsp_valid` high two clock edges later. `rsp_valid` is low in every cycle that does not follow a request in this way, and requests may be issued on back-to-back cycles.
- R2: `rsp_offset` equals bits [9:0] of the request address.
- R3: The set index is the XOR of the six 9-bit slices of the page number `req_va[63:10]`: [18:10], [27:19], [36:28], [45:37], [54:46] and [63:55]. On a hit, `rsp_frame` = set*4 + way, which places the set in bits [10:2] and the way in bits [1:0].
- R4: A hit requires a valid entry in the selected set whose stored 54-bit tag equals the whole page number. A different page that hashes to the same set misses.
- R5: On a miss, `rsp_fault` is high, `rsp_hit` is low and `rsp_frame` is 0. `rsp_hit` and `rsp_fault` are never high together, and both are low when `rsp_valid` is low.
- R6: A maintenance cycle with `mnt_op`=0 (fill) stores `mnt_vpn` into `mnt_set`/`mnt_way` and marks the entry valid. With `mnt_op`=1 (invalidate), it clears that entry's valid bit.
- R7: A lookup sees the table as it stood just before the edge that accepted the request. Maintenance in the same cycle as the request, or in the following cycle, is visible only to later lookups.
- R8: `rsp_victim` on a miss is the lowest-numbered invalid way of the set. If all four ways are valid, it is that set's round-robin pointer. Each pointer is 0 after reset and becomes (way+1) mod 4 whenever a fill writes the way it points to.
- R9: Reset clears every valid bit, so every lookup misses until a fill has taken place.
- R10: If more than one way of a set holds a matching valid tag, the lowest-numbered way is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 64 | Virtual address to translate |
| mnt_valid | input | 1 | Maintenance strobe |
| mnt_op | input | 1 | 0 = fill, 1 = invalidate |
| mnt_set | input | 9 | Target set |
| mnt_way | input | 2 | Target way |
| mnt_vpn | input | 54 | Page number written on fill |
| rsp_valid | output | 1 | Response strobe, two edges after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Page fault (miss) |
| rsp_frame | output | 11 | Physical frame number {set, way} |
| rsp_offset | output | 10 | Untranslated page offset |
| rsp_victim | output | 2 | Suggested replacement way on a miss |

## Verification
Directed lookups run first:
- An empty table separates reset behaviour from stale state.
- A single fill followed by a lookup checks the frame encoding and the offset pass-through.
- A page that differs in two bits but lands in the same set shows that the full tag is compared and that the hash alone does not decide a hit.
- Filling every way of a set drives the victim suggestion from lowest-invalid to round-robin.
- Duplicate tags check the lowest-way priority.
- Maintenance issued in the request cycle and in the cycle after separates the table state at acceptance from later updates.
- A burst of back-to-back requests shows that responses neither merge nor drop.

After that, random fills, invalidates and lookups are drawn from a pool of colliding pages on a few sets. These overflow the four ways and exercise eviction, aliasing and pointer wrap against a bench model of the table.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic {
    MNT_FILL = 1'b0,
    MNT_INV  = 1'b1
  } mnt_op_e;

  localparam int unsigned DEF_VA_W  = 64;
  localparam int unsigned DEF_OFF_W = 10;
  localparam int unsigned DEF_SET_W = 9;
  localparam int unsigned DEF_WAY_W = 2;
endpackage

// File: rtl/xlat_hash.sv
module xlat_hash #(
  parameter int unsigned IN_W  = 54,
  parameter int unsigned OUT_W = 9
) (
  input  logic [IN_W-1:0]  key,
  output logic [OUT_W-1:0] idx
);
  localparam int unsigned CHUNKS = (IN_W + OUT_W - 1) / OUT_W;
  localparam int unsigned PAD_W  = CHUNKS * OUT_W;

  logic [PAD_W-1:0] padded;

  assign padded = PAD_W'(key);

  // XOR fold of every slice into one set index
  always_comb begin
    idx = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      idx = idx ^ padded[c*OUT_W +: OUT_W];
    end
  end
endmodule

// File: rtl/xlat_way_bank.sv
module xlat_way_bank #(
  parameter int unsigned SET_W = 9,
  parameter int unsigned TAG_W = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [SET_W-1:0] rd_set,
  input  logic             wr_en,
  input  logic             clr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  vld_d;

  // tag storage: no reset, written on fill only
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set] <= wr_tag;
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (wr_en) begin
      vld_d[wr_set] = 1'b1;
    end
    if (clr_en) begin
      vld_d[wr_set] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // synchronous read returns pre-write contents
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag <= tag_mem[rd_set];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
    end else if (rd_en) begin
      rd_vld <= vld_q[rd_set];
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned SET_W = 9,
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [SET_W-1:0] rd_set,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] rd_ptr
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0][WAY_W-1:0] ptr_q;
  logic [SETS-1:0][WAY_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (fill_en && (fill_way == ptr_q[fill_set])) begin
      ptr_d[fill_set] = fill_way + WAY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
    end else if (rd_en) begin
      rd_ptr <= ptr_q[rd_set];
    end
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int unsigned TAG_W = 54,
  parameter int unsigned WAY_W = 2
) (
  input  logic [(1<<WAY_W)-1:0][TAG_W-1:0] tags,
  input  logic [(1<<WAY_W)-1:0]            vlds,
  input  logic [TAG_W-1:0]                 key,
  input  logic [WAY_W-1:0]                 rr_ptr,
  output logic                             hit,
  output logic [WAY_W-1:0]                 hit_way,
  output logic [WAY_W-1:0]                 victim
);
  localparam int unsigned WAYS = 1 << WAY_W;

  logic [WAYS-1:0] eq;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      eq[w] = vlds[w] && (tags[w] == key);
    end
  end

  // lowest matching way wins
  always_comb begin
    hit     = |eq;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) begin
        hit_way = WAY_W'(w);
      end
    end
  end

  // lowest invalid way, else round-robin pointer
  always_comb begin
    victim = rr_ptr;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vlds[w]) begin
        victim = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/hashed_page_xlat.sv
module hashed_page_xlat
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W  = DEF_VA_W,
  parameter int unsigned OFF_W = DEF_OFF_W,
  parameter int unsigned SET_W = DEF_SET_W,
  parameter int unsigned WAY_W = DEF_WAY_W,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned FRM_W = SET_W + WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             mnt_valid,
  input  logic             mnt_op,
  input  logic [SET_W-1:0] mnt_set,
  input  logic [WAY_W-1:0] mnt_way,
  input  logic [VPN_W-1:0] mnt_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [FRM_W-1:0] rsp_frame,
  output logic [OFF_W-1:0] rsp_offset,
  output logic [WAY_W-1:0] rsp_victim
);
  localparam int unsigned WAYS = 1 << WAY_W;

  mnt_op_e          op;
  logic             do_fill;
  logic             do_inv;
  logic [SET_W-1:0] req_set;
  logic [VPN_W-1:0] req_vpn;

  assign op      = mnt_op_e'(mnt_op);
  assign do_fill = mnt_valid && (op == MNT_FILL);
  assign do_inv  = mnt_valid && (op == MNT_INV);
  assign req_vpn = req_va[VA_W-1:OFF_W];

  xlat_hash #(.IN_W(VPN_W), .OUT_W(SET_W)) u_hash (
    .key (req_vpn),
    .idx (req_set)
  );

  // stage 1: tag read concurrent with address register
  logic [WAYS-1:0][VPN_W-1:0] rd_tags;
  logic [WAYS-1:0]            rd_vlds;
  logic [WAY_W-1:0]           rd_ptr;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic sel;
    assign sel = (mnt_way == WAY_W'(w));
    xlat_way_bank #(.SET_W(SET_W), .TAG_W(VPN_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (req_valid),
      .rd_set (req_set),
      .wr_en  (do_fill && sel),
      .clr_en (do_inv && sel),
      .wr_set (mnt_set),
      .wr_tag (mnt_vpn),
      .rd_tag (rd_tags[w]),
      .rd_vld (rd_vlds[w])
    );
  end

  xlat_victim #(.SET_W(SET_W), .WAY_W(WAY_W)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (req_valid),
    .rd_set   (req_set),
    .fill_en  (do_fill),
    .fill_set (mnt_set),
    .fill_way (mnt_way),
    .rd_ptr   (rd_ptr)
  );

  logic             s1_valid_q, s1_valid_d;
  logic [VPN_W-1:0] s1_vpn_q;
  logic [OFF_W-1:0] s1_off_q;
  logic [SET_W-1:0] s1_set_q;

  assign s1_valid_d = req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      s1_vpn_q <= req_vpn;
      s1_off_q <= req_va[OFF_W-1:0];
      s1_set_q <= req_set;
    end
  end

  // stage 2: compare and register the response
  logic             m_hit;
  logic [WAY_W-1:0] m_way;
  logic [WAY_W-1:0] m_victim;

  xlat_match #(.TAG_W(VPN_W), .WAY_W(WAY_W)) u_match (
    .tags    (rd_tags),
    .vlds    (rd_vlds),
    .key     (s1_vpn_q),
    .rr_ptr  (rd_ptr),
    .hit     (m_hit),
    .hit_way (m_way),
    .victim  (m_victim)
  );

  logic             valid_d, hit_d, fault_d;
  logic [FRM_W-1:0] frame_d;

  always_comb begin
    valid_d = s1_valid_q;
    hit_d   = s1_valid_q && m_hit;
    fault_d = s1_valid_q && !m_hit;
    frame_d = m_hit ? {s1_set_q, m_way} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_frame  <= '0;
      rsp_offset <= '0;
      rsp_victim <= '0;
    end else if (s1_valid_q) begin
      rsp_frame  <= frame_d;
      rsp_offset <= s1_off_q;
      rsp_victim <= m_victim;
    end
  end
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int unsigned OFF_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_off,
  input logic             mnt_valid,
  input logic             mnt_op,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [OFF_W-1:0] rsp_offset
);
  logic filled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q <= 1'b0;
    end else if (mnt_valid && !mnt_op) begin
      filled_q <= 1'b1;
    end
  end

  assert_rsp_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 rsp_valid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ##2 !rsp_valid);

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_offset == $past(req_off, 2));

  assert_hit_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  assert_status_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit || rsp_fault) |-> rsp_valid);

  assert_no_hit_before_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !filled_q |-> !rsp_hit);
endmodule

bind hashed_page_xlat xlat_chk #(.OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_off    (req_va[OFF_W-1:0]),
  .mnt_valid  (mnt_valid),
  .mnt_op     (mnt_op),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .rsp_offset (rsp_offset)
);

// File: tb/sim_hashed_page_xlat.sv
`timescale 1ns/1ps
module sim_hashed_page_xlat;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_va;
  logic        mnt_valid;
  logic        mnt_op;
  logic [8:0]  mnt_set;
  logic [1:0]  mnt_way;
  logic [53:0] mnt_vpn;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [10:0] rsp_frame;
  logic [9:0]  rsp_offset;
  logic [1:0]  rsp_victim;

  always #2.5 clk = ~clk;

  hashed_page_xlat u0 (.*);

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [53:0] m_tag [512][4];
  bit          m_vld [512][4];
  bit   [1:0]  m_rr  [512];

  function automatic logic [8:0] hsh(input logic [53:0] v);
    logic [8:0] h = '0;
    for (int i = 0; i < 6; i++) h ^= v[i*9 +: 9];
    return h;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic void model_mnt(input bit op, input logic [8:0] s, input logic [1:0] w, input logic [53:0] t);
    if (op == 1'b0) begin
      m_tag[s][w] = t;
      m_vld[s][w] = 1'b1;
      if (m_rr[s] == w) m_rr[s] = w + 2'd1;
    end else begin
      m_vld[s][w] = 1'b0;
    end
  endfunction

  function automatic void model_look(input logic [53:0] v, output bit hit, output logic [1:0] way, output logic [1:0] vic);
    logic [8:0] s = hsh(v);
    hit = 0; way = 0; vic = m_rr[s];
    for (int w = 3; w >= 0; w--) begin
      if (m_vld[s][w] && m_tag[s][w] == v) begin hit = 1; way = 2'(w); end
      if (!m_vld[s][w]) vic = 2'(w);
    end
  endfunction

  task automatic mnt(input bit op, input logic [8:0] s, input logic [1:0] w, input logic [53:0] t);
    @(negedge clk);
    mnt_valid = 1; mnt_op = op; mnt_set = s; mnt_way = w; mnt_vpn = t;
    @(negedge clk);
    mnt_valid = 0;
    model_mnt(op, s, w, t);
  endtask

  task automatic check_rsp(input logic [63:0] va, input bit eh, input logic [1:0] ew, input logic [1:0] ev, input string tag);
    logic [8:0] s = hsh(va[63:10]);
    chk(rsp_valid == 1'b1, {tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit == eh, {tag, " R4 hit"}, 64'(rsp_hit), 64'(eh));
    chk(rsp_fault == !eh, {tag, " R5 fault"}, 64'(rsp_fault), 64'(!eh));
    chk(rsp_offset == va[9:0], {tag, " R2 offset"}, 64'(rsp_offset), 64'(va[9:0]));
    if (eh) chk(rsp_frame == {s, ew}, {tag, " R3 frame"}, 64'(rsp_frame), 64'({s, ew}));
    else begin
      chk(rsp_frame == 11'd0, {tag, " R5 frame"}, 64'(rsp_frame), 64'd0);
      chk(rsp_victim == ev, {tag, " R8 victim"}, 64'(rsp_victim), 64'(ev));
    end
  endtask

  // lookup with optional maintenance in the request cycle (e0) and the one after (e1)
  task automatic look(input logic [63:0] va,
                      input bit e0, input bit op0, input logic [1:0] w0, input logic [53:0] t0,
                      input bit e1, input bit op1, input logic [1:0] w1, input logic [53:0] t1,
                      input string tag);
    bit eh; logic [1:0] ew, ev;
    logic [8:0] s = hsh(va[63:10]);
    model_look(va[63:10], eh, ew, ev);
    @(negedge clk);
    req_valid = 1; req_va = va;
    mnt_valid = e0; mnt_op = op0; mnt_set = s; mnt_way = w0; mnt_vpn = t0;
    @(negedge clk);
    req_valid = 0;
    if (e0) model_mnt(op0, s, w0, t0);
    mnt_valid = e1; mnt_op = op1; mnt_way = w1; mnt_vpn = t1;
    chk(rsp_valid == 1'b0, {tag, " R1 early"}, 64'(rsp_valid), 64'd0);
    @(negedge clk);
    mnt_valid = 0;
    if (e1) model_mnt(op1, s, w1, t1);
    check_rsp(va, eh, ew, ev, tag);
  endtask

  task automatic plain(input logic [63:0] va, input string tag);
    look(va, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  logic [53:0] pool [24];

  initial begin
    logic [53:0] a, b;
    logic [8:0]  sa;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 512; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin m_vld[s][w] = 0; m_tag[s][w] = 0; end
    end
    rst_n = 0; req_valid = 0; req_va = 0;
    mnt_valid = 0; mnt_op = 0; mnt_set = 0; mnt_way = 0; mnt_vpn = 0;
    repeat (4) @(negedge clk);
    chk(rsp_valid == 0 && rsp_hit == 0, "R9 reset outputs", 64'({rsp_valid, rsp_hit}), 64'd0);
    rst_n = 1;

    a  = {$urandom, $urandom} & 54'h3F_FFFF_FFFF_FFFF;
    sa = hsh(a);
    plain({a, 10'h155}, "R9 empty miss");
    mnt(0, sa, 2, a);
    plain({a, 10'h3A7}, "R6 fill hit");
    b = a ^ 54'h201;  // bit 0 and bit 9: same set, different tag
    chk(hsh(b) == sa, "R4 alias setup", 64'(hsh(b)), 64'(sa));
    plain({b, 10'h001}, "R4 alias miss");
    mnt(0, sa, 0, b ^ 54'h402);
    plain({b, 10'h002}, "R8 lowest invalid");
    mnt(0, sa, 1, b ^ 54'h804);
    mnt(0, sa, 3, b ^ 54'h1008);
    plain({b, 10'h003}, "R8 round robin");
    mnt(1, sa, 2, 0);
    plain({a, 10'h004}, "R6 invalidate");
    mnt(0, sa, 3, a);
    mnt(0, sa, 1, a);
    plain({a, 10'h005}, "R10 lowest way");
    look({a, 10'h006}, 1, 1, 1, 0, 1, 0, 2, a, "R7 concurrent");
    plain({a, 10'h007}, "R7 after");

    // back-to-back burst
    begin
      logic [63:0] bv [3];
      bit bh [3]; logic [1:0] bw [3], bvc [3];
      bv[0] = {a, 10'h011}; bv[1] = {b, 10'h022}; bv[2] = {a ^ 54'h1, 10'h033};
      for (int i = 0; i < 3; i++) model_look(bv[i][63:10], bh[i], bw[i], bvc[i]);
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (i >= 2) check_rsp(bv[i-2], bh[i-2], bw[i-2], bvc[i-2], "R1 burst");
        req_valid = (i < 3);
        if (i < 3) req_va = bv[i];
      end
      @(negedge clk);
      chk(rsp_valid == 0, "R1 burst end", 64'(rsp_valid), 64'd0);
    end

    // random phase on colliding pools
    for (int s = 0; s < 4; s++) begin
      logic [53:0] base = {$urandom, $urandom} & 54'h3F_FFFF_FFFF_FFFF;
      for (int k = 0; k < 6; k++) pool[s*6+k] = base ^ ((54'(k) << 9) | 54'(k));
    end
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 9);
      logic [53:0] v = pool[$urandom_range(0, 23)];
      bit h; logic [1:0] w, vc;
      model_look(v, h, w, vc);
      if (r < 4) plain({v, 10'($urandom)}, "rand lookup");
      else if (r < 8) mnt(0, hsh(v), ($urandom_range(0, 3) == 0) ? 2'($urandom) : vc, v);
      else mnt(1, hsh(v), 2'($urandom), 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule